// File: doc/BRIEF.md
# Binary32 to Binary16 Narrowing Converter

This block takes a 32-bit IEEE binary32 operand with a 3-bit rounding-mode code and returns the matching 16-bit binary16 value one stage later. Rounding works on the raw 32-bit word. An increment of one is added at the position of the lowest fraction bit that the half format keeps, and the exponent is read again after that add, so a carry out of the fraction moves the value into the next binade. The rounded exponent then decides the result class: signed zero, binary16 subnormal, normal, or infinity. Infinities and NaNs pass through with their upper fraction bits kept.

A valid/ready handshake sits on the operand side and on the result side, with one output register between them. A stalled result stays in the register until the consumer takes it. The block raises no exception flags. Subnormal results come from a plain right shift of the already rounded significand and are not rounded again.

Top module: `f2h_narrow`

## Requirements
- R1: `in_ready` is high when the output register is empty or `out_ready` is high. An operand accepted on a clock edge appears on `out_half` with `out_valid` high from that edge on. While `out_valid` is high and `out_ready` is low, `out_half` and `out_valid` hold.
- R2: While reset is asserted and just after it, `out_valid` is low and `in_ready` is high.
- R3: An operand whose exponent field (bits 30:23) is zero gets no rounding and yields a zero carrying the operand's sign bit.
- R4: Mode code 0 (nearest, ties to even) adds one at bit 13 when bit 12 is set and at least one of bit 13 or bits 11:0 is set.
- R5: Mode code 3 (toward +inf) adds one at bit 13 when bits 12:0 are nonzero and the sign is 0. Mode code 2 (toward -inf) does so when bits 12:0 are nonzero and the sign is 1.
- R6: Mode codes 1, 4, 5, 6 and 7 add nothing; the discarded bits 12:0 are dropped.
- R7: A carry from the rounding add propagates into the exponent before the result class is chosen.
- R8: With rounded unbiased exponent e in [-14, 15], the result exponent field is e+15 and the result fraction is rounded bits 22:13.
- R9: With e in [-24, -15], the result exponent field is zero and the fraction is {1, rounded bits 22:13} shifted right by (-e-14).
- R10: With e below -24, the result is a zero carrying the operand's sign.
- R11: With e from 16 up to 128, the result is infinity: exponent field all ones, fraction zero.
- R12: An operand exponent of all ones gives exponent field all ones and fraction bits 22:13. If the operand is a NaN whose bits 22:13 are all zero, the result fraction becomes 0x200, so no NaN leaves as infinity.
- R13: Result bit 15 always equals operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_word | input | 32 | Binary32 operand |
| in_rmode | input | 3 | Rounding mode code (0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest-max treated as truncate, 5-7 truncate) |
| out_valid | output | 1 | Result register holds a value |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_half | output | 16 | Binary16 result |

## Verification
The assertions assume the consumer may lower `out_ready` at any time. They also assume the producer has no obligation to hold `in_valid`, so only the block's own output side is held to stability. They assume nothing about operand values: any 32-bit pattern, NaN payloads and zero-exponent words included, is legal. The stimulus draws `out_ready` at random with a bias toward acceptance, so stalls of several cycles occur. Operand exponents are steered toward the zero, all-ones and near-half-range bands, so that the subnormal, overflow and carry paths are reached often. All eight mode codes are drawn, including the unused ones.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
    // source format
    localparam int SW     = 32;
    localparam int SE     = 8;
    localparam int SF     = 23;
    // destination format
    localparam int HW     = 16;
    localparam int HE     = 5;
    localparam int HF     = 10;
    // derived
    localparam int DROP   = SF - HF;                 // first kept fraction bit
    localparam int SBIAS  = (1 << (SE - 1)) - 1;
    localparam int HBIAS  = (1 << (HE - 1)) - 1;
    localparam int HMIN_E = 1 - HBIAS;               // lowest normal exponent
    localparam int HSUB_E = HMIN_E - HF;             // lowest subnormal exponent
    localparam int HOVF_E = HBIAS + 1;               // first overflowing exponent

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TRUNC     = 3'd1,
        RM_NEG_INF   = 3'd2,
        RM_POS_INF   = 3'd3,
        RM_NEAR_MAX  = 3'd4
    } rmode_e;

    typedef struct packed {
        logic          vld;
        logic [HW-1:0] half;
    } ostage_t;
endpackage

// File: rtl/f2h_round_inc.sv
module f2h_round_inc
    import f2h_pkg::*;
(
    input  logic          sign,
    input  logic [SE-1:0] exp,
    input  logic [DROP:0] tail,   // tail[DROP] is the kept LSB
    input  logic [2:0]    rmode,
    output logic          inc
);
    logic guard, low_any, all_any, exp_ok;

    always_comb begin
        guard   = tail[DROP-1];
        low_any = |tail[DROP-2:0];
        all_any = |tail[DROP-1:0];
        exp_ok  = (exp != '0) && (exp != '1);
        inc     = 1'b0;
        if (exp_ok) begin
            case (rmode)
                RM_NEAR_EVEN: inc = guard && (tail[DROP] || low_any);
                RM_POS_INF:   inc = all_any && !sign;
                RM_NEG_INF:   inc = all_any && sign;
                default:      inc = 1'b0;   // truncate, near-max and spare codes
            endcase
        end
    end
endmodule

// File: rtl/f2h_pack.sv
module f2h_pack
    import f2h_pkg::*;
(
    input  logic [SW-1:DROP] hi,      // rounded word, bits above the dropped tail
    input  logic             nan_in,  // operand was a NaN
    output logic [HW-1:0]    half
);
    logic          sign;
    logic [SE-1:0] exp;
    logic [HF-1:0] frac;
    logic [HF:0]   mant;
    int            e;
    int            shamt;

    always_comb begin
        sign  = hi[SW-1];
        exp   = hi[SW-2 -: SE];
        frac  = hi[DROP+HF-1 : DROP];
        mant  = {1'b1, frac};
        e     = int'(exp) - SBIAS;
        shamt = HMIN_E - e;
        if (exp == '1) begin
            half = {sign, {HE{1'b1}}, frac};
            if (nan_in && (frac == '0))
                half[HF-1] = 1'b1;
        end else if (e < HSUB_E) begin
            half = {sign, {(HW-1){1'b0}}};
        end else if (e < HMIN_E) begin
            half = {sign, {HE{1'b0}}, HF'(mant >> shamt)};
        end else if (e < HOVF_E) begin
            half = {sign, HE'(e + HBIAS), frac};
        end else begin
            half = {sign, {HE{1'b1}}, {HF{1'b0}}};
        end
    end
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
    import f2h_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_word,
    input  logic [2:0]    in_rmode,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [HW-1:0] out_half
);
    logic          inc;
    logic          nan_in;
    logic [SW-1:0] rnd_word;
    logic [HW-1:0] res;
    ostage_t       st_d, st_q;

    f2h_round_inc u_inc (
        .sign  (in_word[SW-1]),
        .exp   (in_word[SW-2 -: SE]),
        .tail  (in_word[DROP:0]),
        .rmode (in_rmode),
        .inc   (inc)
    );

    always_comb begin
        rnd_word = in_word + (SW'(inc) << DROP);
        nan_in   = (&in_word[SW-2 -: SE]) && (|in_word[SF-1:0]);
    end

    f2h_pack u_pack (
        .hi     (rnd_word[SW-1:DROP]),
        .nan_in (nan_in),
        .half   (res)
    );

    always_comb begin
        in_ready = !st_q.vld || out_ready;
        st_d     = st_q;
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.half = res;
        end else if (out_ready) begin
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_half  = st_q.half;
endmodule

// File: rtl/f2h_narrow_chk.sv
module f2h_narrow_chk
    import f2h_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [SW-1:0] in_word,
    input logic [2:0]    in_rmode,
    input logic          out_valid,
    input logic          out_ready,
    input logic [HW-1:0] out_half
);
    logic fire, trunc_mode, in_nan, out_nan, half_norm;

    always_comb begin
        fire       = in_valid && in_ready;
        trunc_mode = !(in_rmode == 3'd0 || in_rmode == 3'd2 || in_rmode == 3'd3);
        in_nan     = (&in_word[SW-2 -: SE]) && (|in_word[SF-1:0]);
        out_nan    = (&out_half[HW-2 -: HE]) && (|out_half[HF-1:0]);
        half_norm  = (int'(in_word[SW-2 -: SE]) >= SBIAS + HMIN_E) &&
                     (int'(in_word[SW-2 -: SE]) <  SBIAS + HOVF_E);
    end

    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_half));

    p_fire_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);

    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    p_empty_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_sign_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_half[HW-1] == $past(in_word[SW-1]));

    p_nan_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_nan == $past(in_nan));

    p_zero_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (in_word[SW-2 -: SE] == '0) |=> out_half[HW-2:0] == '0);

    p_trunc_frac_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && trunc_mode && half_norm |=> out_half[HF-1:0] == $past(in_word[SF-1:DROP]));
endmodule

bind f2h_narrow f2h_narrow_chk u_chk (.*);

// File: tb/f2h_narrow_bench.sv
`timescale 1ns/1ps
module f2h_narrow_bench;
    localparam int NDIR  = 20;
    localparam int NRAND = 800;
    localparam int N     = NDIR + NRAND;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic [2:0]  in_rmode;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_half;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] w_arr [N];
    logic [2:0]  m_arr [N];
    string       t_arr [N];

    always #2 clk = ~clk;   // 250 MHz

    f2h_narrow u_f2h_narrow (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v,
                       input string what);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    function automatic logic [15:0] model(input logic [31:0] x, input logic [2:0] m);
        logic        s;
        int          ex, e, mant, up;
        logic [12:0] tl;
        s  = x[31];
        ex = int'(x[30:23]);
        tl = x[12:0];
        if (ex == 255) begin
            if (x[22:0] == 0) return {s, 5'h1f, 10'h0};
            if (x[22:13] == 0) return {s, 5'h1f, 10'h200};
            return {s, 5'h1f, x[22:13]};
        end
        if (ex == 0) return {s, 15'h0};
        up = 0;
        if (m == 3'd0 && tl[12] && (x[13] || tl[11:0] != 0)) up = 1;
        if (m == 3'd3 && !s && tl != 0) up = 1;
        if (m == 3'd2 && s && tl != 0) up = 1;
        mant = 1024 + int'(x[22:13]) + up;
        if (mant == 2048) begin mant = 1024; ex = ex + 1; end
        e = ex - 127;
        if (e < -24) return {s, 15'h0};
        if (e < -14) return {s, 5'h0, 10'(mant >> (-e - 14))};
        if (e < 16)  return {s, 5'(e + 15), 10'(mant)};
        return {s, 5'h1f, 10'h0};
    endfunction

    function automatic string class_tag(input logic [31:0] x);
        int e;
        if (x[30:23] == 8'hff) return "R12";
        if (x[30:23] == 8'h00) return "R3";
        e = int'(x[30:23]) - 127;
        if (e < -24) return "R10";
        if (e < -14) return "R9";
        if (e < 16)  return "R8";
        return "R11";
    endfunction

    task automatic put(input int i, input logic [31:0] w, input logic [2:0] m, input string t);
        w_arr[i] = w; m_arr[i] = m; t_arr[i] = t;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int idx, got;
        logic hold;
        logic [15:0] held;
        void'($urandom(32'h5eed_1234));
        put(0,  32'h3f800000, 3'd0, "R8");   // 1.0 -> 3c00
        put(1,  32'h477fe000, 3'd0, "R8");   // largest half
        put(2,  32'h477ff000, 3'd0, "R11");  // rounds up to overflow
        put(3,  32'h477ff000, 3'd1, "R6");   // truncates to 7bff
        put(4,  32'h33800000, 3'd0, "R9");   // smallest subnormal
        put(5,  32'h33000000, 3'd0, "R10");  // below subnormal range
        put(6,  32'h7f800001, 3'd0, "R12");  // NaN with empty upper payload
        put(7,  32'hff800000, 3'd3, "R12");  // -inf
        put(8,  32'h00000001, 3'd3, "R3");   // binary32 subnormal
        put(9,  32'h80000001, 3'd2, "R3");
        put(10, 32'h3f7ff000, 3'd0, "R7");   // carry into exponent
        put(11, 32'h3f800001, 3'd3, "R5");
        put(12, 32'h3f800001, 3'd2, "R5");
        put(13, 32'hbf800001, 3'd2, "R5");
        put(14, 32'h3f801000, 3'd0, "R4");   // tie, even LSB stays
        put(15, 32'h3f803000, 3'd0, "R4");   // tie, odd LSB rounds
        put(16, 32'h3f801001, 3'd0, "R4");   // above tie
        put(17, 32'h3f803fff, 3'd4, "R6");   // near-max code truncates
        put(18, 32'h3f803fff, 3'd7, "R6");   // spare code truncates
        put(19, 32'hc2f6e979, 3'd0, "R13");  // negative normal
        for (int i = NDIR; i < N; i++) begin
            logic [31:0] w;
            int k;
            w = $urandom;
            k = $urandom % 5;
            if (k == 0) w[30:23] = 8'(100 + $urandom % 50);
            else if (k == 1) w[30:23] = 8'(139 + $urandom % 8);
            else if (k == 2) w[30:23] = ($urandom % 2) ? 8'hff : 8'h00;
            else if (k == 3) w[30:23] = 8'(110 + $urandom % 6);
            put(i, w, 3'($urandom % 8), class_tag(w));
        end

        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_rmode = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", {31'b0, out_valid}, 32'd0, "out_valid in reset");
        chk("R2", {31'b0, in_ready}, 32'd1, "in_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {31'b0, out_valid}, 32'd0, "out_valid after reset");

        idx = 0; got = 0; hold = 1'b0; held = '0;
        while (got < N) begin
            @(negedge clk);
            if (hold) begin
                chk("R1", {31'b0, out_valid}, 32'd1, "valid held in stall");
                chk("R1", {16'b0, out_half}, {16'b0, held}, "data held in stall");
                hold = 1'b0;
            end
            out_ready = ($urandom % 4) != 0;
            if (idx < N && ($urandom % 6) != 0) begin
                in_valid = 1'b1; in_word = w_arr[idx]; in_rmode = m_arr[idx];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (out_valid && out_ready) begin
                chk(t_arr[got], {16'b0, out_half}, {16'b0, model(w_arr[got], m_arr[got])},
                    $sformatf("word %h mode %0d", w_arr[got], m_arr[got]));
                chk("R13", {31'b0, out_half[15]}, {31'b0, w_arr[got][31]}, "sign");
                got++;
            end else if (out_valid) begin
                hold = 1'b1; held = out_half;
            end
            if (in_valid && in_ready) idx++;
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule